// File: doc/BRIEF.md
# Single-Tile Depth Buffer with One-Cycle Clear

This block holds the depth values of one square screen tile on chip. A renderer that bins its geometry by tile sends every pixel of a tile through this block before moving to the next tile. Each request carries a tile-local column and row, a new depth, a compare mode and a flag that marks a shadow test. The block answers with a pass/fail result and with the depth that the new value was compared against. On a pass, outside shadow tests, the new depth is stored.

Between tiles the renderer pulses a clear. The clear drops a valid flag on every entry in a single cycle, so there is no sweep of the storage array. An entry without a valid flag reads as the far plane, which is all ones. Requests are accepted one per cycle and give results at a fixed latency. A request that follows a write to the same location in the next cycle sees the written value.

Top module: `tile_zbuf`

## Requirements
- R1: While reset is held and afterwards until a request is made, `rsp_valid` is low. After reset every entry reads as the far-plane value.
- R2: The tile is 32 by 32 entries. Entry address is row times 32 plus column, with a 5-bit column `req_x` and a 5-bit row `req_y`. Distinct (x, y) pairs never share storage.
- R3: A request sampled at clock edge N gives `rsp_valid` high, with its result, after edge N+2 and for that one cycle only. Results come back in request order.
- R4: `req_mode` selects the compare: 0 passes when new depth < stored depth, 1 passes when new <= stored, 2 always passes, 3 never passes.
- R5: Outside shadow tests (`req_shadow` = 0), a passing request stores its depth. A failing request leaves the stored depth unchanged.
- R6: With `req_shadow` = 1 the result is reported and the stored depth is never changed.
- R7: A one-cycle `tile_clear` makes every entry read as the far plane for all later requests. A request sampled on the same edge as the clear already sees the cleared tile.
- R8: A request accepted before a clear reports its result against the pre-clear contents. Its write does not survive into the new tile.
- R9: Back-to-back requests to the same entry each see the result of the one before. No cycle is lost.
- R10: Depth is 24 bits and the far plane is 24'hFFFFFF. `rsp_old_z` reports the depth that the request was compared against.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Pixel request present this cycle |
| req_x | input | 5 | Tile-local column |
| req_y | input | 5 | Tile-local row |
| req_z | input | 24 | New depth |
| req_mode | input | 2 | Compare mode (0 less, 1 less-equal, 2 always, 3 never) |
| req_shadow | input | 1 | Shadow test: compare only, no store |
| tile_clear | input | 1 | One-cycle clear of the whole tile |
| rsp_valid | output | 1 | Result present |
| rsp_pass | output | 1 | Compare result |
| rsp_old_z | output | 24 | Depth the request was compared against |

## Verification
The hardest cases to reach are the ones where a clear lands on the same edge as a write still in the pipeline, or on the same edge as a forwarded read to the same entry. Here a wrong priority would let an old tile's depth leak into the new one. The stimulus places clears directly behind and alongside back-to-back requests to one entry, then probes that entry. A long random phase then confines addresses to a few entries and mixes in clears. Collisions, forwarding and clears therefore overlap often, and a reference model tracks the expected contents in request order.

// File: rtl/tzb_pkg.sv
package tzb_pkg;
   typedef enum logic [1:0] {
      CMP_LT   = 2'd0,
      CMP_LE   = 2'd1,
      CMP_ALL  = 2'd2,
      CMP_NONE = 2'd3
   } cmp_mode_e;
endpackage

// File: rtl/tzb_store.sv
// Depth storage with registered read and a flop vector of per-entry valid flags.
module tzb_store #(
   parameter int ADDR_W  = 10,
   parameter int DEPTH_W = 24
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               rd_en,
   input  logic [ADDR_W-1:0]  rd_addr,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [DEPTH_W-1:0] wr_data,
   output logic [DEPTH_W-1:0] rd_z,
   output logic               rd_hit
);
   localparam int ENTRIES = 1 << ADDR_W;

   logic [DEPTH_W-1:0] mem [ENTRIES];
   logic [ENTRIES-1:0] vld;

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
      if (rd_en) rd_z <= mem[rd_addr];
   end

   // A clear outranks a write on the same edge: that write belongs to the old tile.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld    <= '0;
         rd_hit <= 1'b0;
      end else begin
         if (clr)        vld          <= '0;
         else if (wr_en) vld[wr_addr] <= 1'b1;
         if (rd_en)      rd_hit       <= vld[rd_addr];
      end
   end
endmodule

// File: rtl/tzb_cmp.sv
module tzb_cmp #(
   parameter int DEPTH_W = 24
) (
   input  tzb_pkg::cmp_mode_e mode,
   input  logic [DEPTH_W-1:0] new_z,
   input  logic [DEPTH_W-1:0] old_z,
   output logic               pass
);
   always_comb begin
      unique case (mode)
         tzb_pkg::CMP_LT:   pass = new_z <  old_z;
         tzb_pkg::CMP_LE:   pass = new_z <= old_z;
         tzb_pkg::CMP_ALL:  pass = 1'b1;
         default:           pass = 1'b0;
      endcase
   end
endmodule

// File: rtl/tile_zbuf.sv
module tile_zbuf #(
   parameter int TILE_BITS = 5,
   parameter int DEPTH_W   = 24
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic [TILE_BITS-1:0] req_x,
   input  logic [TILE_BITS-1:0] req_y,
   input  logic [DEPTH_W-1:0]   req_z,
   input  logic [1:0]           req_mode,
   input  logic                 req_shadow,
   input  logic                 tile_clear,
   output logic                 rsp_valid,
   output logic                 rsp_pass,
   output logic [DEPTH_W-1:0]   rsp_old_z
);
   localparam int ADDR_W = 2 * TILE_BITS;
   localparam logic [DEPTH_W-1:0] FAR_Z = '1;

   if (TILE_BITS < 1 || TILE_BITS > 6) begin : g_bad_tile
      $error("tile_zbuf: TILE_BITS out of range");
   end
   if (DEPTH_W < 2) begin : g_bad_depth
      $error("tile_zbuf: DEPTH_W too small");
   end

   logic [ADDR_W-1:0] req_addr;
   assign req_addr = {req_y, req_x};

   // stage-1 registers: request accepted on the previous edge
   logic               s1_v, s1_shadow, s1_fresh, s1_fwd;
   logic [ADDR_W-1:0]  s1_addr;
   logic [DEPTH_W-1:0] s1_z, s1_fwd_z;
   tzb_pkg::cmp_mode_e s1_mode;

   logic               st_hit, s1_hit, s1_pass, s1_wr;
   logic [DEPTH_W-1:0] st_z, s1_old;

   tzb_store #(.ADDR_W(ADDR_W), .DEPTH_W(DEPTH_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (tile_clear),
      .rd_en   (req_valid),
      .rd_addr (req_addr),
      .wr_en   (s1_wr),
      .wr_addr (s1_addr),
      .wr_data (s1_z),
      .rd_z    (st_z),
      .rd_hit  (st_hit)
   );

   // Effective old depth: a same-edge clear wins, then the forwarded write, then storage.
   assign s1_hit = !s1_fresh && (s1_fwd || st_hit);
   assign s1_old = !s1_hit ? FAR_Z : (s1_fwd ? s1_fwd_z : st_z);

   tzb_cmp #(.DEPTH_W(DEPTH_W)) u_cmp (
      .mode  (s1_mode),
      .new_z (s1_z),
      .old_z (s1_old),
      .pass  (s1_pass)
   );

   assign s1_wr = s1_v && s1_pass && !s1_shadow;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_v      <= 1'b0;
         s1_shadow <= 1'b0;
         s1_fresh  <= 1'b0;
         s1_fwd    <= 1'b0;
         s1_addr   <= '0;
         s1_z      <= '0;
         s1_fwd_z  <= '0;
         s1_mode   <= tzb_pkg::CMP_NONE;
      end else begin
         s1_v      <= req_valid;
         s1_fresh  <= tile_clear;
         s1_fwd    <= req_valid && s1_wr && (s1_addr == req_addr);
         s1_fwd_z  <= s1_z;
         if (req_valid) begin
            s1_shadow <= req_shadow;
            s1_addr   <= req_addr;
            s1_z      <= req_z;
            s1_mode   <= tzb_pkg::cmp_mode_e'(req_mode);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_pass  <= 1'b0;
         rsp_old_z <= '0;
      end else begin
         rsp_valid <= s1_v;
         rsp_pass  <= s1_v && s1_pass;
         rsp_old_z <= s1_old;
      end
   end
endmodule

// File: rtl/tzb_checker.sv
module tzb_checker #(
   parameter int DEPTH_W = 24
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic [1:0]         req_mode,
   input logic [DEPTH_W-1:0] req_z,
   input logic               tile_clear,
   input logic               rsp_valid,
   input logic               rsp_pass,
   input logic [DEPTH_W-1:0] rsp_old_z
);
   localparam logic [DEPTH_W-1:0] FAR_Z = '1;

   // R3: every accepted request answers two edges later
   a_r3_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> ##2 rsp_valid);
   // R3: no result without a request
   a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> ##2 !rsp_valid);
   // R4: mode 2 always passes
   a_r4_always: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_mode == 2'd2) |-> ##2 rsp_pass);
   // R4: mode 3 never passes
   a_r4_never: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_mode == 2'd3) |-> ##2 !rsp_pass);
   // R4: strict less compare against the reported old depth
   a_r4_less: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_mode == 2'd0) |-> ##2 (rsp_pass == ($past(req_z, 2) < rsp_old_z)));
   // R7: a request on the clear edge sees the far plane
   a_r7_clear_far: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && tile_clear) |-> ##2 (rsp_old_z == FAR_Z));
endmodule

bind tile_zbuf tzb_checker #(.DEPTH_W(DEPTH_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_mode   (req_mode),
   .req_z      (req_z),
   .tile_clear (tile_clear),
   .rsp_valid  (rsp_valid),
   .rsp_pass   (rsp_pass),
   .rsp_old_z  (rsp_old_z)
);

// File: tb/tile_zbuf_tb.sv
module tile_zbuf_tb;
   localparam logic [23:0] FAR = 24'hFFFFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [4:0]  req_x = '0, req_y = '0;
   logic [23:0] req_z = '0;
   logic [1:0]  req_mode = '0;
   logic        req_shadow = 1'b0;
   logic        tile_clear = 1'b0;
   logic        rsp_valid, rsp_pass;
   logic [23:0] rsp_old_z;

   always #2.5 clk = ~clk;

   tile_zbuf u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_x(req_x), .req_y(req_y),
      .req_z(req_z), .req_mode(req_mode), .req_shadow(req_shadow), .tile_clear(tile_clear),
      .rsp_valid(rsp_valid), .rsp_pass(rsp_pass), .rsp_old_z(rsp_old_z)
   );

   int vectors = 0;
   int errors  = 0;
   int cyc     = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // reference model
   logic [23:0] mz [1024];
   bit          mv [1024];

   bit          q_pass [$];
   logic [23:0] q_old  [$];
   int          q_cyc  [$];
   string       q_tag  [$];

   task automatic fail(string tag, string what, longint act, longint exp);
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
   endtask

   // drive one cycle; v=0 with clr=1 is a bare clear
   task automatic drive(bit v, int x, int y, logic [23:0] z, int mode, bit shadow, bit clr, string tag);
      int a;
      logic [23:0] old;
      bit p;
      @(negedge clk);
      req_valid = v; req_x = 5'(x); req_y = 5'(y); req_z = z;
      req_mode = 2'(mode); req_shadow = shadow; tile_clear = clr;
      if (clr) foreach (mv[i]) mv[i] = 1'b0;
      if (v) begin
         a   = y * 32 + x;               // R2 address map
         old = mv[a] ? mz[a] : FAR;
         case (mode)
            0: p = z <  old;
            1: p = z <= old;
            2: p = 1'b1;
            default: p = 1'b0;
         endcase
         if (p && !shadow) begin mz[a] = z; mv[a] = 1'b1; end
         q_pass.push_back(p); q_old.push_back(old);
         q_cyc.push_back(cyc + 2); q_tag.push_back(tag);
      end
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) drive(1'b0, 0, 0, '0, 0, 1'b0, 1'b0, "");
   endtask

   // monitor
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (q_pass.size() == 0) begin
            vectors++;
            fail("R3", "unexpected rsp_valid", 1, 0);
         end else begin
            bit p; logic [23:0] o; int c; string t;
            p = q_pass.pop_front(); o = q_old.pop_front();
            c = q_cyc.pop_front();  t = q_tag.pop_front();
            vectors++;
            if (c != cyc)            fail("R3", "result cycle", cyc, c);
            else if (rsp_pass != p)  fail(t, "pass", rsp_pass, p);
            else if (rsp_old_z != o) fail(t, "old_z", rsp_old_z, o);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      vectors++;
      fail("watchdog", "timeout", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      foreach (mv[i]) mv[i] = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      vectors++;
      if (rsp_valid !== 1'b0) fail("R1", "rsp_valid in reset", rsp_valid, 0);
      rst_n = 1'b1;
      idle(3);
      vectors++;
      if (rsp_valid !== 1'b0) fail("R1", "rsp_valid after reset", rsp_valid, 0);

      // R1, R10: fresh entries read far; mode 1 with far depth passes
      drive(1, 7, 9, FAR, 1, 1, 0, "R1");
      drive(1, 7, 9, FAR, 0, 0, 0, "R10");
      // R4, R5: less, equal, less-equal, always, never
      drive(1, 3, 3, 24'h100, 0, 0, 0, "R5");
      drive(1, 3, 3, 24'h100, 0, 0, 0, "R4");
      drive(1, 3, 3, 24'h100, 1, 0, 0, "R4");
      drive(1, 3, 3, 24'h200, 0, 0, 0, "R5");
      drive(1, 3, 3, 24'h300, 2, 0, 0, "R4");
      drive(1, 3, 3, 24'h001, 3, 0, 0, "R4");
      drive(1, 3, 3, 24'h050, 0, 1, 0, "R6");   // shadow pass, no store
      drive(1, 3, 3, 24'h000, 3, 1, 0, "R6");   // probe: still 0x300
      // R2: neighbours that differ only across a row boundary
      drive(1, 31, 0, 24'h011, 2, 0, 0, "R2");
      drive(1, 0, 1, 24'h022, 2, 0, 0, "R2");
      drive(1, 31, 0, 24'h0, 3, 1, 0, "R2");
      drive(1, 0, 1, 24'h0, 3, 1, 0, "R2");
      idle(2);
      // R9: back-to-back descending depths on one entry
      for (int i = 0; i < 6; i++) drive(1, 12, 20, 24'(1000 - 100 * i), 0, 0, 0, "R9");
      idle(1);
      // R7: bare clear, then probe
      drive(0, 0, 0, '0, 0, 0, 1, "");
      drive(1, 3, 3, 24'h0, 3, 1, 0, "R7");
      drive(1, 12, 20, 24'h0, 3, 1, 0, "R7");
      // R8: writes in flight across a clear, plus request on the clear edge
      drive(1, 5, 5, 24'h040, 0, 0, 0, "R8");
      drive(1, 5, 5, 24'h030, 0, 0, 0, "R8");
      drive(1, 5, 5, 24'h0FF, 0, 0, 1, "R7");
      drive(1, 5, 5, 24'h100, 1, 0, 0, "R9");
      drive(1, 6, 6, 24'h010, 2, 0, 0, "R8");
      drive(0, 0, 0, '0, 0, 0, 1, "");
      drive(1, 6, 6, 24'h0, 3, 1, 0, "R8");
      idle(3);
      // random mix over a few entries
      for (int i = 0; i < 3000; i++) begin
         int r = $urandom_range(0, 63);
         drive(r != 0, $urandom_range(0, 3), $urandom_range(0, 1) * 31, 24'($urandom_range(0, 40)) << 4,
               $urandom_range(0, 3), $urandom_range(0, 7) == 0, $urandom_range(0, 31) == 0, "R5");
      end
      idle(4);
      vectors++;
      if (q_pass.size() != 0) fail("R3", "missing results", q_pass.size(), 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule